// File: doc/BRIEF.md
# Serial Clock Register Front End

This block is the register side of a small serial real-time clock. A host selects the device, shifts in a command byte and then shifts data bytes in or out, one bit per strobe. The command byte selects both the target register and the transfer direction. The block holds two status bytes, two interrupt-setting bytes, a clock-adjust byte and a scratch byte. Accesses to the calendar record are passed to an external timekeeping core through a small parallel port that carries a byte index, write data, a write strobe and read data.

Status byte 1 carries sticky event flags. A flag is cleared once its byte has been loaded for shifting out, and an event that arrives after that load is kept for the next read. Writing a one to the lowest bit of status byte 1 resets the register set. A power-off event input also returns every register to zero, but leaves the power-off flag set.

Top module: `rtc_cmd_regs`

## Requirements
- R1: Command codes 0x60 to 0x6F address eight registers, two codes each (write/read): status1 0x60/0x61, status2 0x62/0x63, full date 0x64/0x65, time only 0x66/0x67, interrupt byte 1 0x68/0x69, interrupt byte 2 0x6B/0x6A, clock adjust 0x6D/0x6C, scratch 0x6F/0x6E. For every register the other code of its pair reads.
- R2: Every byte is sent least significant bit first. `sdi` is sampled on a cycle where `sel` and `bit_stb` are both high. During a read, `sdo` holds bit k of the current data byte before the strobe of bit k. `sdo` is 0 on the cycle after `sel` is low.
- R3: Status1 layout: bit 1 selects 24-hour mode (also on `cfg_24h`), bits 3:2 are general-purpose, bit 0 reads 0, and bits 7..4 are the power-off, low-power, INT2 and INT1 flags.
- R4: Loading status1 for output clears all four flags. An event that arrives after that load shows on the next read.
- R5: Pulses on `ev_int1`, `ev_int2` and `ev_lowpwr` set status1 bits 4, 5 and 6. Each bit stays set until it is read.
- R6: A status1 write with bit 0 set pulses `soft_rst` and clears every register and flag to 0x00. The other bits of that byte are discarded. A status1 write with bit 0 clear does not pulse `soft_rst`.
- R7: After `rst_n` or an `ev_pwroff` pulse, every register reads 0x00 except status1, which reads 0x80 once and 0x00 after that.
- R8: Status2 is fully read/write. Its bits 3:0 drive `cfg_int1_mode` and its bit 6 drives `cfg_int2_en`.
- R9: A full-date access moves 7 bytes at timekeeper indices 0..6. A time-only access moves 3 bytes at indices 4..6. Each written byte pulses `tk_we` with `tk_wdata`. Read bytes come from `tk_rdata`.
- R10: In a burst, a byte beyond the length of the register reads 0x00 and is not written.
- R11: A command byte outside 0x60..0x6F writes nothing and reads 0x00.
- R12: Dropping `sel` in the middle of a byte discards that byte. The next selection starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel | input | 1 | Device select, high for the whole transaction |
| bit_stb | input | 1 | One-cycle strobe per serial bit |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| ev_int1 | input | 1 | INT1 event pulse |
| ev_int2 | input | 1 | INT2 event pulse |
| ev_lowpwr | input | 1 | Low-supply event pulse |
| ev_pwroff | input | 1 | Power-loss event pulse |
| tk_addr | output | 3 | Timekeeper byte index |
| tk_rdata | input | 8 | Timekeeper read byte |
| tk_wdata | output | 8 | Timekeeper write byte |
| tk_we | output | 1 | Timekeeper write strobe |
| soft_rst | output | 1 | Soft reset pulse |
| cfg_24h | output | 1 | 24-hour mode |
| cfg_int1_mode | output | 4 | INT1 mode field |
| cfg_int2_en | output | 1 | INT2 enable |

## Verification
The bench builds the block with a 7-byte date record and a 3-byte time window. This places the time window at indices 4..6 and puts the first out-of-range burst byte at index 7, so both record ends and the overrun are exercised. At these sizes an 8-byte burst is short enough to check every byte against a bench-side model of the timekeeping core.

// File: rtl/rtc_cmd_regs.sv
module rtc_cmd_regs #(
  parameter int DATE_BYTES = 7,
  parameter int TIME_BYTES = 3,
  localparam int IW = $clog2(DATE_BYTES + 2),
  localparam int AW = $clog2(DATE_BYTES),
  localparam int TIME_BASE = DATE_BYTES - TIME_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          bit_stb,
  input  logic          sdi,
  output logic          sdo,
  input  logic          ev_int1,
  input  logic          ev_int2,
  input  logic          ev_lowpwr,
  input  logic          ev_pwroff,
  output logic [AW-1:0] tk_addr,
  input  logic [7:0]    tk_rdata,
  output logic [7:0]    tk_wdata,
  output logic          tk_we,
  output logic          soft_rst,
  output logic          cfg_24h,
  output logic [3:0]    cfg_int1_mode,
  output logic          cfg_int2_en
);
  logic [2:0] bitcnt;
  logic in_data;
  logic [7:0] cmd, tx;
  logic [6:0] rx;
  logic [IW-1:0] bidx, len, base, aidx;
  logic [2:0] s1cfg;
  logic [3:0] flags;
  logic [7:0] s2, ir1, ir2, adj, frr, rd_byte;

  wire [7:0] byte_in   = {sdi, rx};
  wire       byte_done = sel && bit_stb && bitcnt == 3'd7;
  wire [7:0] cur_cmd   = in_data ? cmd : byte_in;
  wire       valid     = cur_cmd[7:4] == 4'h6;
  wire [2:0] pair      = cur_cmd[3:1];
  wire       is_wr     = valid && (pair >= 3'd5 ? cur_cmd[0] : ~cur_cmd[0]);
  wire [IW-1:0] lidx   = in_data ? bidx + 1'b1 : '0;
  wire       in_rng    = aidx < len;
  wire       clr_flags = byte_done && valid && !is_wr && pair == 3'd0 && in_rng;
  wire       do_wr     = byte_done && in_data && is_wr && in_rng;

  assign aidx          = is_wr ? bidx : lidx;
  assign tk_addr       = AW'(base + aidx);
  assign tk_wdata      = byte_in;
  assign tk_we         = do_wr && (pair == 3'd2 || pair == 3'd3);
  assign soft_rst      = do_wr && pair == 3'd0 && byte_in[0];
  assign sdo           = tx[0];
  assign cfg_24h       = s1cfg[0];
  assign cfg_int1_mode = s2[3:0];
  assign cfg_int2_en   = s2[6];

  always_comb begin
    len  = IW'(1);
    base = '0;
    if (pair == 3'd2) len = IW'(DATE_BYTES);
    if (pair == 3'd3) begin
      len  = IW'(TIME_BYTES);
      base = IW'(TIME_BASE);
    end
    case (pair)
      3'd0:    rd_byte = {flags, s1cfg, 1'b0};
      3'd1:    rd_byte = s2;
      3'd2,
      3'd3:    rd_byte = tk_rdata;
      3'd4:    rd_byte = ir1;
      3'd5:    rd_byte = ir2;
      3'd6:    rd_byte = adj;
      default: rd_byte = frr;
    endcase
    if (!valid || is_wr || !in_rng) rd_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0; in_data <= 1'b0; bidx <= '0;
      cmd <= '0; rx <= '0; tx <= '0;
    end else if (!sel) begin
      bitcnt <= '0; in_data <= 1'b0; bidx <= '0; tx <= '0;
    end else if (bit_stb) begin
      bitcnt <= bitcnt + 3'd1;
      rx     <= byte_in[7:1];
      if (bitcnt == 3'd7) begin
        if (!in_data) begin
          cmd <= byte_in; in_data <= 1'b1; bidx <= '0;
        end else if (bidx < len) begin
          bidx <= bidx + 1'b1;
        end
        tx <= rd_byte;
      end else begin
        tx <= tx >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1cfg <= '0; flags <= 4'b1000;
      s2 <= '0; ir1 <= '0; ir2 <= '0; adj <= '0; frr <= '0;
    end else if (ev_pwroff) begin
      s1cfg <= '0; flags <= 4'b1000;
      s2 <= '0; ir1 <= '0; ir2 <= '0; adj <= '0; frr <= '0;
    end else if (soft_rst) begin
      s1cfg <= '0; flags <= '0;
      s2 <= '0; ir1 <= '0; ir2 <= '0; adj <= '0; frr <= '0;
    end else begin
      flags <= (clr_flags ? 4'b0000 : flags) | {1'b0, ev_lowpwr, ev_int2, ev_int1};
      if (do_wr) begin
        case (pair)
          3'd0:    s1cfg <= byte_in[3:1];
          3'd1:    s2    <= byte_in;
          3'd4:    ir1   <= byte_in;
          3'd5:    ir2   <= byte_in;
          3'd6:    adj   <= byte_in;
          3'd7:    frr   <= byte_in;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_cmd_regs_chk.sv
module rtc_cmd_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       bit_stb,
  input logic       sdo,
  input logic       ev_int1,
  input logic       ev_int2,
  input logic       ev_lowpwr,
  input logic       ev_pwroff,
  input logic       soft_rst,
  input logic       tk_we,
  input logic       in_data,
  input logic [7:0] cmd,
  input logic [3:0] flags,
  input logic [7:0] s2,
  input logic [7:0] adj,
  input logic [7:0] frr,
  input logic       clr_flags
);
  a_r2_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !sdo);
  a_r4_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags && !ev_int1 && !ev_int2 && !ev_lowpwr && !ev_pwroff && !soft_rst |=> flags == 4'b0000);
  a_r5_int1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ev_int1 && !ev_pwroff && !soft_rst |=> flags[0]);
  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !ev_pwroff |=> flags == 4'b0000 && s2 == 8'h00 && adj == 8'h00 && frr == 8'h00);
  a_r7_power_off: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pwroff |=> flags == 4'b1000 && s2 == 8'h00 && frr == 8'h00);
  a_r9_we_framed: assert property (@(posedge clk) disable iff (!rst_n)
    tk_we |-> sel && bit_stb && in_data);
  a_r11_bad_cmd_inert: assert property (@(posedge clk) disable iff (!rst_n)
    sel && bit_stb && in_data && cmd[7:4] != 4'h6 && !ev_pwroff |=> $stable(s2) && $stable(adj) && $stable(frr));
endmodule

bind rtc_cmd_regs rtc_cmd_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel(sel), .bit_stb(bit_stb), .sdo(sdo),
  .ev_int1(ev_int1), .ev_int2(ev_int2), .ev_lowpwr(ev_lowpwr), .ev_pwroff(ev_pwroff),
  .soft_rst(soft_rst), .tk_we(tk_we), .in_data(in_data), .cmd(cmd), .flags(flags),
  .s2(s2), .adj(adj), .frr(frr), .clr_flags(clr_flags)
);

// File: tb/rtc_cmd_regs_tb.sv
module rtc_cmd_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, bit_stb = 1'b0, sdi = 1'b0;
  logic ev_int1 = 1'b0, ev_int2 = 1'b0, ev_lowpwr = 1'b0, ev_pwroff = 1'b0;
  logic sdo, tk_we, soft_rst, cfg_24h, cfg_int2_en;
  logic [2:0] tk_addr;
  logic [7:0] tk_rdata, tk_wdata;
  logic [3:0] cfg_int1_mode;
  logic [7:0] tk_mem [8];
  int n_chk = 0, n_bad = 0, n_srst = 0;
  logic [7:0] v, r;

  always #5 clk = ~clk;

  rtc_cmd_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .bit_stb(bit_stb), .sdi(sdi), .sdo(sdo),
    .ev_int1(ev_int1), .ev_int2(ev_int2), .ev_lowpwr(ev_lowpwr), .ev_pwroff(ev_pwroff),
    .tk_addr(tk_addr), .tk_rdata(tk_rdata), .tk_wdata(tk_wdata), .tk_we(tk_we),
    .soft_rst(soft_rst), .cfg_24h(cfg_24h), .cfg_int1_mode(cfg_int1_mode),
    .cfg_int2_en(cfg_int2_en)
  );

  assign tk_rdata = tk_mem[tk_addr];
  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < 8; i++) tk_mem[i] <= 8'h00;
    else if (tk_we) tk_mem[tk_addr] <= tk_wdata;
    if (rst_n && soft_rst) n_srst <= n_srst + 1;
  end

  task automatic chk(input string req, input [7:0] act, input [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xbyte(input [7:0] wb, output [7:0] rb);
    for (int i = 0; i < 8; i++) begin
      rb[i] = sdo; sdi = wb[i]; bit_stb = 1'b1;
      @(negedge clk); bit_stb = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic open_t;  sel = 1'b1; @(negedge clk); endtask
  task automatic close_t; sel = 1'b0; sdi = 1'b0; @(negedge clk); @(negedge clk); endtask

  task automatic wr_reg(input [7:0] c, input [7:0] d);
    logic [7:0] t;
    open_t; xbyte(c, t); xbyte(d, t); close_t;
  endtask

  task automatic rd_reg(input [7:0] c, output [7:0] d);
    logic [7:0] t;
    open_t; xbyte(c, t); xbyte(8'h00, d); close_t;
  endtask

  task automatic half_byte(input [7:0] c);
    logic [7:0] t;
    open_t;
    if (c != 8'h00) xbyte(c, t);
    for (int i = 0; i < 4; i++) begin
      sdi = 1'b1; bit_stb = 1'b1; @(negedge clk); bit_stb = 1'b0; @(negedge clk);
    end
    close_t;
  endtask

  task automatic t_reset;
    chk("R2 idle sdo", {7'd0, sdo}, 8'h00);
    rd_reg(8'h61, v); chk("R7 first status1 after reset", v, 8'h80);
    rd_reg(8'h61, v); chk("R4 status1 cleared by read", v, 8'h00);
    rd_reg(8'h6E, v); chk("R7 scratch after reset", v, 8'h00);
  endtask

  task automatic t_status1;
    wr_reg(8'h60, 8'h0E);
    rd_reg(8'h61, v); chk("R3 status1 readback", v, 8'h0E);
    chk("R3 cfg_24h", {7'd0, cfg_24h}, 8'h01);
    chk("R6 no soft reset when bit0 clear", 8'(n_srst), 8'h00);
  endtask

  task automatic t_status2;
    wr_reg(8'h62, 8'hA5);
    rd_reg(8'h63, v); chk("R8 status2 readback", v, 8'hA5);
    chk("R8 int1 mode", {4'd0, cfg_int1_mode}, 8'h05);
    chk("R8 int2 enable off", {7'd0, cfg_int2_en}, 8'h00);
    wr_reg(8'h62, 8'h40);
    chk("R8 int2 enable on", {7'd0, cfg_int2_en}, 8'h01);
  endtask

  task automatic t_pairs;
    wr_reg(8'h6B, 8'h11); rd_reg(8'h6A, v); chk("R1 int2 byte swapped codes", v, 8'h11);
    wr_reg(8'h68, 8'h22); rd_reg(8'h69, v); chk("R1 int1 byte", v, 8'h22);
    wr_reg(8'h6D, 8'h33); rd_reg(8'h6C, v); chk("R1 clock adjust", v, 8'h33);
    wr_reg(8'h6F, 8'h44); rd_reg(8'h6E, v); chk("R1 scratch", v, 8'h44);
    open_t; xbyte(8'h6A, r); xbyte(8'h99, v); close_t;
    chk("R1 0x6A is a read", v, 8'h11);
    rd_reg(8'h6A, v); chk("R1 0x6A did not write", v, 8'h11);
  endtask

  task automatic t_events;
    ev_int1 = 1'b1; @(negedge clk); ev_int1 = 1'b0;
    ev_int2 = 1'b1; @(negedge clk); ev_int2 = 1'b0;
    ev_lowpwr = 1'b1; @(negedge clk); ev_lowpwr = 1'b0;
    rd_reg(8'h61, v); chk("R5 flags set", v, 8'h7E);
    rd_reg(8'h61, v); chk("R4 flags cleared", v, 8'h0E);
  endtask

  task automatic t_event_in_read;
    open_t; xbyte(8'h61, r);
    ev_int1 = 1'b1; @(negedge clk); ev_int1 = 1'b0;
    xbyte(8'h00, v); close_t;
    chk("R4 late event not in this read", v, 8'h0E);
    rd_reg(8'h61, v); chk("R4 late event survives", v, 8'h1E);
    rd_reg(8'h61, v); chk("R4 cleared again", v, 8'h0E);
  endtask

  task automatic t_date;
    open_t; xbyte(8'h64, r);
    for (int i = 0; i < 8; i++) xbyte(8'h10 + 8'(i), r);
    close_t;
    for (int i = 0; i < 7; i++) chk("R9 date write", tk_mem[i], 8'h10 + 8'(i));
    chk("R10 date overrun not written", tk_mem[7], 8'h00);
    open_t; xbyte(8'h65, r);
    for (int i = 0; i < 8; i++) begin
      xbyte(8'h00, v);
      chk("R9 R10 date read", v, i < 7 ? 8'h10 + 8'(i) : 8'h00);
    end
    close_t;
    open_t; xbyte(8'h66, r);
    for (int i = 0; i < 3; i++) xbyte(8'hA0 + 8'(i), r);
    close_t;
    for (int i = 0; i < 7; i++)
      chk("R9 time window", tk_mem[i], i < 4 ? 8'h10 + 8'(i) : 8'hA0 + 8'(i - 4));
    open_t; xbyte(8'h67, r);
    for (int i = 0; i < 4; i++) begin
      xbyte(8'h00, v);
      chk("R9 R10 time read", v, i < 3 ? 8'hA0 + 8'(i) : 8'h00);
    end
    close_t;
  endtask

  task automatic t_single_burst;
    open_t; xbyte(8'h6E, r); xbyte(8'h00, v); chk("R10 first byte", v, 8'h44);
    xbyte(8'h00, v); chk("R10 second byte zero", v, 8'h00); close_t;
    open_t; xbyte(8'h6F, r); xbyte(8'h55, r); xbyte(8'h66, r); close_t;
    rd_reg(8'h6E, v); chk("R10 extra write ignored", v, 8'h55);
  endtask

  task automatic t_invalid;
    wr_reg(8'h50, 8'hFF);
    rd_reg(8'h6E, v); chk("R11 bad write inert", v, 8'h55);
    rd_reg(8'h71, v); chk("R11 bad read 0x71", v, 8'h00);
    rd_reg(8'h5F, v); chk("R11 bad read 0x5F", v, 8'h00);
  endtask

  task automatic t_partial;
    half_byte(8'h6F);
    rd_reg(8'h6E, v); chk("R12 partial data dropped", v, 8'h55);
    half_byte(8'h00);
    rd_reg(8'h6E, v); chk("R12 partial command dropped", v, 8'h55);
  endtask

  task automatic t_soft_reset;
    wr_reg(8'h60, 8'h0F);
    chk("R6 soft_rst pulsed once", 8'(n_srst), 8'h01);
    rd_reg(8'h61, v); chk("R6 status1 zero", v, 8'h00);
    rd_reg(8'h63, v); chk("R6 status2 zero", v, 8'h00);
    rd_reg(8'h6C, v); chk("R6 adjust zero", v, 8'h00);
    rd_reg(8'h6E, v); chk("R6 scratch zero", v, 8'h00);
  endtask

  task automatic t_power_off;
    wr_reg(8'h6F, 8'h77); wr_reg(8'h62, 8'h12);
    ev_pwroff = 1'b1; @(negedge clk); ev_pwroff = 1'b0;
    rd_reg(8'h61, v); chk("R7 power-off flag", v, 8'h80);
    rd_reg(8'h6E, v); chk("R7 scratch cleared", v, 8'h00);
    rd_reg(8'h63, v); chk("R7 status2 cleared", v, 8'h00);
    rd_reg(8'h61, v); chk("R7 flag read once", v, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_status1;
    t_status2;
    t_pairs;
    t_events;
    t_event_in_read;
    t_date;
    t_single_burst;
    t_invalid;
    t_partial;
    t_soft_reset;
    t_power_off;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule